// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block observes the clock line and data line of a two-wire serial bus from inside a synchronous system-clock domain and never drives either line. Each line is brought across with a two-flop synchronizer and then passed through a counting deglitch filter, so that short noise spikes do not reach the rest of the logic. From the cleaned lines it recognises start and stop conditions, emitting a one-cycle strobe for each, and keeps a busy flag that spans the time from a start to the matching stop.

It also tracks bus timing. After a stop, the bus is reported free only once it has stayed idle for the minimum free time. A start that arrives before that, a repeated start whose setup after the clock rose is too short, a start whose hold before the clock falls is too short, and a stop whose setup after the clock rose is too short each set their own bit in a sticky violation vector, cleared only by reset. One parameter picks standard or fast timing; a second gives the system clock period in nanoseconds, and all windows are converted to cycle counts by rounding up.

Top module: `i2c_cond_watch`

## Requirements
- R1: After reset, scl_o and sda_o are 1, start_o and stop_o are 0, busy_o is 0, free_o is 1 and viol_o is 0.
- R2: A level on either input that lasts fewer than the spike width in cycles (ceil(100 ns / period) in standard mode, ceil(50 ns / period) in fast mode) leaves the filtered output unchanged and produces no strobe.
- R3: A level held for at least the spike width appears on the filtered output exactly 2 + spike-width clock edges after the input changes.
- R4: A falling filtered data line while the filtered clock line is high produces start_o high for exactly one cycle, and busy_o is 1 in that cycle.
- R5: A rising filtered data line while the filtered clock line is high produces stop_o high for exactly one cycle and clears busy_o in that cycle.
- R6: A start while busy (repeated start) produces a start strobe and leaves busy_o at 1.
- R7: A data line change while the filtered clock line is low produces no start or stop strobe and does not change busy_o.
- R8: free_o falls on every start and stop, stays 0 while busy, and returns to 1 only after the bus has been idle for the free time (ceil(4700 ns / period) cycles standard, ceil(1300 ns / period) fast) since the stop.
- R9: viol_o bit 0 sets when a start is seen while not busy and free_o is 0.
- R10: viol_o bit 1 sets when a start comes less than the start setup time (4700 ns standard, 600 ns fast) after the filtered clock line rose.
- R11: viol_o bit 2 sets when the filtered clock line falls less than the start hold time (4000 ns standard, 600 ns fast) after a start.
- R12: viol_o bit 3 sets when a stop comes less than the stop setup time (4000 ns standard, 600 ns fast) after the filtered clock line rose.
- R13: Every viol_o bit, once set, stays set until reset.
- R14: With the fast-mode parameter set, the shorter spike width applies, so a spike rejected in standard mode can be accepted in fast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| scl_o | output | 1 | Filtered clock line |
| sda_o | output | 1 | Filtered data line |
| start_o | output | 1 | One-cycle start (or repeated start) strobe |
| stop_o | output | 1 | One-cycle stop strobe |
| busy_o | output | 1 | Bus held between start and stop |
| free_o | output | 1 | Bus idle for at least the free time |
| viol_o | output | 4 | Sticky timing flags: bit 0 early start, bit 1 start setup, bit 2 start hold, bit 3 stop setup |

## Verification
The hardest state to reach is a timing violation on a repeated start, since it needs a started bus, a clock low phase with the data line raised, and then a clock high phase cut short before the data line falls, all with every edge held past the spike width so the filter passes it. The bench drives such sequences with per-scenario tasks that hold each level a chosen number of cycles, placing the measured intervals well clear of the threshold on both the passing and the failing side, and resets between violation scenarios so each sticky bit is seen alone. A second instance in fast mode shares the stimulus so that a single spike length separates the two filter widths.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Round a duration in ns up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bit positions in the sticky violation vector.
    localparam int V_EARLY = 0;
    localparam int V_SUSTA = 1;
    localparam int V_HDSTA = 2;
    localparam int V_SUSTO = 3;
    localparam int V_W     = 4;

endpackage

// File: rtl/i2cw_deglitch.sv
module i2cw_deglitch #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          level;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = line_i;
        st_d.sync2 = st_q.sync1;
        if (st_q.sync2 != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = st_q.sync2;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync1: 1'b1, sync2: 1'b1, level: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.level;

endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic start_o,
    output logic stop_o,
    output logic busy_o
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic start;
        logic stop;
        logic busy;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        start_evt = st_q.scl_prev & scl_f & st_q.sda_prev & ~sda_f;
        stop_evt  = st_q.scl_prev & scl_f & ~st_q.sda_prev & sda_f;

        st_d          = st_q;
        st_d.scl_prev = scl_f;
        st_d.sda_prev = sda_f;
        st_d.start    = start_evt;
        st_d.stop     = stop_evt;
        if (start_evt) begin
            st_d.busy = 1'b1;
        end else if (stop_evt) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, start: 1'b0,
                      stop: 1'b0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign stop_o  = st_q.stop;
    assign busy_o  = st_q.busy;

endmodule

// File: rtl/i2cw_timing.sv
module i2cw_timing
    import i2cw_pkg::*;
#(
    parameter int FREE_CYC  = 470,
    parameter int SUSTA_CYC = 470,
    parameter int HDSTA_CYC = 400,
    parameter int SUSTO_CYC = 400
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_f,
    input  logic           start_evt,
    input  logic           stop_evt,
    input  logic           busy_i,
    output logic           free_o,
    output logic [V_W-1:0] viol_o
);
    localparam int SAT_CYC = max_of(SUSTA_CYC, SUSTO_CYC);
    localparam int TOP_CYC = max_of(max_of(SAT_CYC, HDSTA_CYC), FREE_CYC);
    localparam int CW      = $clog2(TOP_CYC + 1) + 1;

    localparam logic [CW-1:0] SAT_L   = CW'(SAT_CYC);
    localparam logic [CW-1:0] SUSTA_L = CW'(SUSTA_CYC);
    localparam logic [CW-1:0] SUSTO_L = CW'(SUSTO_CYC);
    localparam logic [CW-1:0] HD_LAST = CW'(HDSTA_CYC - 1);
    localparam logic [CW-1:0] FR_LAST = CW'(FREE_CYC - 1);

    typedef struct packed {
        logic           scl_prev;
        logic [CW-1:0]  hi_cnt;
        logic           hold_act;
        logic [CW-1:0]  hold_cnt;
        logic [CW-1:0]  idle_cnt;
        logic           free;
        logic [V_W-1:0] viol;
    } tim_t;

    tim_t st_d, st_q;
    logic scl_fall;

    always_comb begin
        st_d          = st_q;
        st_d.scl_prev = scl_f;
        scl_fall      = st_q.scl_prev & ~scl_f;

        // Length of the current clock-high phase, saturating.
        if (!scl_f) begin
            st_d.hi_cnt = '0;
        end else if (st_q.hi_cnt != SAT_L) begin
            st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end

        // Hold window after a start.
        if (start_evt) begin
            st_d.hold_act = 1'b1;
            st_d.hold_cnt = CW'(1);
        end else if (st_q.hold_act) begin
            if (scl_fall) begin
                st_d.viol[V_HDSTA] = 1'b1;
                st_d.hold_act      = 1'b0;
            end else if (st_q.hold_cnt >= HD_LAST) begin
                st_d.hold_act = 1'b0;
            end else begin
                st_d.hold_cnt = st_q.hold_cnt + 1'b1;
            end
        end

        // Conditions, setup checks and free-time tracking.
        if (start_evt) begin
            if (st_q.hi_cnt < SUSTA_L) begin
                st_d.viol[V_SUSTA] = 1'b1;
            end
            if (!busy_i && !st_q.free) begin
                st_d.viol[V_EARLY] = 1'b1;
            end
            st_d.free     = 1'b0;
            st_d.idle_cnt = '0;
        end else if (stop_evt) begin
            if (st_q.hi_cnt < SUSTO_L) begin
                st_d.viol[V_SUSTO] = 1'b1;
            end
            st_d.free     = 1'b0;
            st_d.idle_cnt = '0;
        end else if (!busy_i && !st_q.free) begin
            if (st_q.idle_cnt == FR_LAST) begin
                st_d.free = 1'b1;
            end else begin
                st_d.idle_cnt = st_q.idle_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_prev: 1'b1, hi_cnt: SAT_L, hold_act: 1'b0,
                      hold_cnt: '0, idle_cnt: '0, free: 1'b1, viol: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign free_o = st_q.free;
    assign viol_o = st_q.viol;

endmodule

// File: rtl/i2c_cond_watch.sv
module i2c_cond_watch
    import i2cw_pkg::*;
#(
    parameter bit FAST_MODE     = 1'b0,
    parameter int CLK_PERIOD_NS = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           scl_o,
    output logic           sda_o,
    output logic           start_o,
    output logic           stop_o,
    output logic           busy_o,
    output logic           free_o,
    output logic [V_W-1:0] viol_o
);
    localparam int SPIKE_NS = FAST_MODE ? 50   : 100;
    localparam int FREE_NS  = FAST_MODE ? 1300 : 4700;
    localparam int SUSTA_NS = FAST_MODE ? 600  : 4700;
    localparam int HDSTA_NS = FAST_MODE ? 600  : 4000;
    localparam int SUSTO_NS = FAST_MODE ? 600  : 4000;

    localparam int SPIKE_CYC = max_of(ns_to_cyc(SPIKE_NS, CLK_PERIOD_NS), 1);
    localparam int FREE_CYC  = max_of(ns_to_cyc(FREE_NS,  CLK_PERIOD_NS), 1);
    localparam int SUSTA_CYC = max_of(ns_to_cyc(SUSTA_NS, CLK_PERIOD_NS), 1);
    localparam int HDSTA_CYC = max_of(ns_to_cyc(HDSTA_NS, CLK_PERIOD_NS), 1);
    localparam int SUSTO_CYC = max_of(ns_to_cyc(SUSTO_NS, CLK_PERIOD_NS), 1);

    localparam int LINES = 2;   // index 0: clock line, 1: data line

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    logic             start_evt;
    logic             stop_evt;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        i2cw_deglitch #(.FILT_CYC(SPIKE_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    assign scl_o = clean_lines[0];
    assign sda_o = clean_lines[1];

    i2cw_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[0]),
        .sda_f     (clean_lines[1]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .start_o   (start_o),
        .stop_o    (stop_o),
        .busy_o    (busy_o)
    );

    i2cw_timing #(
        .FREE_CYC  (FREE_CYC),
        .SUSTA_CYC (SUSTA_CYC),
        .HDSTA_CYC (HDSTA_CYC),
        .SUSTO_CYC (SUSTO_CYC)
    ) u_tim (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[0]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .busy_i    (busy_o),
        .free_o    (free_o),
        .viol_o    (viol_o)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_o,
    input logic       sda_o,
    input logic       start_o,
    input logic       stop_o,
    input logic       busy_o,
    input logic       free_o,
    input logic [3:0] viol_o
);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    assert_no_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    assert_stop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    assert_start_clk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($past(scl_o) && !$past(sda_o)));

    assert_stop_clk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> ($past(scl_o) && $past(sda_o)));

    assert_busy_not_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !free_o);

    assert_viol_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((viol_o & $past(viol_o)) == $past(viol_o)));

endmodule

bind i2c_cond_watch i2cw_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .start_o (start_o),
    .stop_o  (stop_o),
    .busy_o  (busy_o),
    .free_o  (free_o),
    .viol_o  (viol_o)
);

// File: tb/i2c_cond_watch_bench.sv
module i2c_cond_watch_bench;
    localparam int CLK_NS = 10;
    // Standard mode at 10 ns: spike 10, free 470, start setup 470,
    // start hold 400, stop setup 400 cycles. Fast spike: 5 cycles.

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_r = 1'b1;
    logic       sda_r = 1'b1;
    logic       scl_o, sda_o, start_o, stop_o, busy_o, free_o;
    logic [3:0] viol_o;
    logic       scl_f, sda_f, start_f, stop_f, busy_f, free_f;
    logic [3:0] viol_f;

    int n_tests = 0;
    int n_fail  = 0;
    int n_start = 0, n_stop = 0, n_start_f = 0;

    always #(CLK_NS/2) clk = ~clk;

    i2c_cond_watch #(.FAST_MODE(1'b0), .CLK_PERIOD_NS(CLK_NS)) u_i2c_cond_watch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_r),
        .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .stop_o(stop_o),
        .busy_o(busy_o), .free_o(free_o), .viol_o(viol_o));

    i2c_cond_watch #(.FAST_MODE(1'b1), .CLK_PERIOD_NS(CLK_NS)) u_i2c_cond_watch_fast (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_r),
        .scl_o(scl_f), .sda_o(sda_f), .start_o(start_f), .stop_o(stop_f),
        .busy_o(busy_f), .free_o(free_f), .viol_o(viol_f));

    // Count strobe cycles (values sampled before this edge's updates).
    always @(posedge clk) begin
        if (start_o) n_start++;
        if (stop_o)  n_stop++;
        if (start_f) n_start_f++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl_r = 1'b1; sda_r = 1'b1;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    // Start from idle: data falls, clock falls after hold_c cycles.
    task automatic bus_start(input int hold_c);
        sda_r = 1'b0; wait_cyc(hold_c);
        scl_r = 1'b0; wait_cyc(20);
    endtask

    // Repeated start from clock low.
    task automatic bus_rstart(input int setup_c);
        sda_r = 1'b1; wait_cyc(20);
        scl_r = 1'b1; wait_cyc(setup_c);
        sda_r = 1'b0; wait_cyc(500);
        scl_r = 1'b0; wait_cyc(20);
    endtask

    // Stop from clock low.
    task automatic bus_stop(input int setup_c);
        sda_r = 1'b0; wait_cyc(20);
        scl_r = 1'b1; wait_cyc(setup_c);
        sda_r = 1'b1; wait_cyc(20);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 scl_o", scl_o, 1);
        chk("R1 sda_o", sda_o, 1);
        chk("R1 start/stop", {start_o, stop_o}, 0);
        chk("R1 busy_o", busy_o, 0);
        chk("R1 free_o", free_o, 1);
        chk("R1 viol_o", viol_o, 0);
    endtask

    task automatic t_glitch();
        int s0 = n_start, sf = n_start_f;
        sda_r = 1'b0; wait_cyc(6); sda_r = 1'b1; wait_cyc(30);
        chk("R2 sda spike no start", n_start - s0, 0);
        chk("R2 sda spike busy", busy_o, 0);
        chk("R14 fast accepts 6-cycle spike", n_start_f - sf, 1);
        scl_r = 1'b0; wait_cyc(9); scl_r = 1'b1;
        wait_cyc(1); chk("R2 scl spike level", scl_o, 1);
        wait_cyc(30); chk("R2 scl spike level later", scl_o, 1);
    endtask

    task automatic t_start_latency();
        int s0;
        do_reset();
        s0 = n_start;
        sda_r = 1'b0;
        repeat (11) @(negedge clk);
        #1 chk("R3 before 12 edges", sda_o, 1);
        @(negedge clk);
        #1 chk("R3 at 12 edges", sda_o, 0);
        wait_cyc(500);
        scl_r = 1'b0; wait_cyc(20);
        chk("R4 one start pulse", n_start - s0, 1);
        chk("R4 busy set", busy_o, 1);
        chk("R8 free low when busy", free_o, 0);
        chk("R11 long hold no flag", viol_o, 0);
    endtask

    task automatic t_data_low();
        int s0 = n_start, p0 = n_stop;
        sda_r = 1'b1; wait_cyc(30); sda_r = 1'b0; wait_cyc(30);
        sda_r = 1'b1; wait_cyc(30);
        scl_r = 1'b1; wait_cyc(500); scl_r = 1'b0; wait_cyc(30);
        sda_r = 1'b0; wait_cyc(30);
        chk("R7 no start on data", n_start - s0, 0);
        chk("R7 no stop on data", n_stop - p0, 0);
        chk("R7 busy kept", busy_o, 1);
    endtask

    task automatic t_rstart();
        int s0 = n_start;
        bus_rstart(500);
        chk("R6 repeated start pulse", n_start - s0, 1);
        chk("R6 busy stays", busy_o, 1);
        chk("R10 long setup no flag", viol_o, 0);
    endtask

    task automatic t_stop_free();
        int p0 = n_stop;
        bus_stop(500);
        chk("R5 one stop pulse", n_stop - p0, 1);
        chk("R5 busy cleared", busy_o, 0);
        chk("R8 free low after stop", free_o, 0);
        chk("R12 long stop setup no flag", viol_o, 0);
        wait_cyc(500);
        chk("R8 free after idle", free_o, 1);
    endtask

    task automatic t_early_start();
        bus_start(500);
        bus_stop(500);
        wait_cyc(80);
        chk("R8 free still low", free_o, 0);
        bus_start(500);
        chk("R9 early start flag", viol_o, 4'b0001);
        bus_stop(500);
        wait_cyc(600);
        bus_start(500);
        bus_stop(500);
        chk("R13 flag sticky", viol_o, 4'b0001);
    endtask

    task automatic t_setup();
        do_reset();
        bus_start(500);
        bus_rstart(100);
        chk("R10 start setup flag", viol_o, 4'b0010);
    endtask

    task automatic t_hold();
        do_reset();
        bus_start(100);
        chk("R11 start hold flag", viol_o, 4'b0100);
    endtask

    task automatic t_stop_setup();
        do_reset();
        bus_start(500);
        bus_stop(100);
        chk("R12 stop setup flag", viol_o, 4'b1000);
        chk("R5 busy cleared after short stop", busy_o, 0);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_start_latency();
        t_data_low();
        t_rstart();
        t_stop_free();
        t_early_start();
        t_setup();
        t_hold();
        t_stop_setup();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule